// File: doc/BRIEF.md
# E1 Multiframe Resynchronization Supervisor

This block decides when the E1 receive framer has to restart its alignment searches. Software asks for a restart with two command bits, each acting on its rising edge. One bit forces a full search: doubleframe alignment and, in CRC multiframe format, multiframe alignment as well. The other bit forces a search of the multiframe alignment alone. Both searches are issued as one-clock request pulses to the framer. The framer reports back with a one-clock pulse each time it sees a CRC multiframe alignment pattern.

After an arming event, the block supervises the result. An arming event is doubleframe alignment being regained, or a resync command, while CRC format is active. The block counts frame strobes, one every 125 us. It declares multiframe alignment when two patterns arrive a non-zero whole number of 16-frame periods (2 ms) apart. When automatic resync is enabled and no such pair appears within 64 frames (8 ms), the block escalates to a full doubleframe search.

Top module: `mf_resync_sup`

## Requirements
- R1: While reset is high and in the cycle after it, `df_search_req`, `mf_search_req` and `mf_aligned` are 0.
- R2: A 0-to-1 change on `frc_cmd` gives a one-clock pulse on `df_search_req` in the cycle after it is sampled; holding the bit high gives no further pulse.
- R3: A rising edge of `frc_cmd` also pulses `mf_search_req`, together with `df_search_req`, only when `fmt_sel` is 2'b10 (CRC multiframe format); for the values 2'b00, 2'b01 and 2'b11 `mf_search_req` stays 0.
- R4: A rising edge of `mfrc_cmd` with `fmt_sel` = 2'b10 pulses `mf_search_req` only and leaves `df_search_req` at 0; with any other `fmt_sel` value it has no effect on either output.
- R5: After arming, two `mf_pat` pulses separated by a non-zero multiple of 16 frame strobes set `mf_aligned` in the cycle after the second pulse is sampled.
- R6: A second pattern whose distance from the first is not a multiple of 16 frames does not set `mf_aligned`; it becomes the new reference for the next pattern.
- R7: With `auto_en` = 1, if no valid pattern pair has been seen when the 64th frame strobe after arming is sampled, both `df_search_req` and `mf_search_req` pulse for one clock in the following cycle.
- R8: With `auto_en` = 0 no request is raised, however many frames pass without a valid pattern pair.
- R9: `mf_aligned` is 0 in every cycle in which a search request pulse is high.
- R10: A rising edge of `df_sync` in CRC format restarts the 64-frame window from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-clock strobe per received frame (125 us) |
| df_sync | input | 1 | Doubleframe alignment held by the framer |
| fmt_sel | input | 2 | Frame format select; 2'b10 is CRC multiframe |
| auto_en | input | 1 | Enable escalation when the multiframe window expires |
| frc_cmd | input | 1 | Full resync command bit, acts on its rising edge |
| mfrc_cmd | input | 1 | Multiframe-only resync command bit, acts on its rising edge |
| mf_pat | input | 1 | One-clock pulse when a multiframe alignment pattern is seen |
| df_search_req | output | 1 | Pulse: restart the doubleframe search |
| mf_search_req | output | 1 | Pulse: restart the multiframe search |
| mf_aligned | output | 1 | Multiframe alignment confirmed by a valid pattern pair |

## Verification
The command edges are tried under all four format codes. This separates the full-search path from the multiframe-only path, and separates CRC format from the rest. Pattern pairs are driven at a distance of exactly 16 frames and at a distance of 10 frames followed by a further 16. These show that the spacing rule holds and that a mismatched pattern becomes the new reference point. The window is run to 63 and to 64 frames with escalation enabled and disabled. It is also run across a doubleframe re-acquisition in mid-count, which shows that the timer really restarts rather than continuing.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  localparam logic [1:0] FMT_CRC = 2'b10;
  localparam int unsigned DEF_MF_FRAMES  = 16;
  localparam int unsigned DEF_WIN_FRAMES = 64;
endpackage

// File: rtl/mfr_edge.sv
module mfr_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev[i] <= 1'b0;
      else     prev[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev[i];
  end
endmodule

// File: rtl/mfr_window.sv
module mfr_window #(
  parameter int unsigned MF_FRAMES  = 16,
  parameter int unsigned WIN_FRAMES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic crc_on,
  input  logic auto_en,
  input  logic arm,
  input  logic tick,
  input  logic pat,
  output logic pair_ok,
  output logic timeout
);
  localparam int unsigned FT_W = $clog2(WIN_FRAMES);
  localparam int unsigned MF_W = $clog2(MF_FRAMES);
  localparam logic [FT_W-1:0] FT_LAST = FT_W'(WIN_FRAMES - 1);
  localparam logic [MF_W-1:0] MF_LAST = MF_W'(MF_FRAMES - 1);

  logic            hunting;
  logic            seen;
  logic            far;
  logic [FT_W-1:0] ft;
  logic [MF_W-1:0] phase;
  logic            spacing_ok;

  // distance is a whole, non-zero number of multiframe periods
  assign spacing_ok = far && (phase == '0);
  assign pair_ok    = hunting && seen && pat && spacing_ok && !arm;
  assign timeout    = hunting && auto_en && tick && (ft == FT_LAST) && !arm && !pair_ok;

  always_ff @(posedge clk) begin
    if (rst || !crc_on) begin
      hunting <= 1'b0;
      seen    <= 1'b0;
      far     <= 1'b0;
      ft      <= '0;
      phase   <= '0;
    end else if (arm) begin
      hunting <= 1'b1;
      seen    <= 1'b0;
      far     <= 1'b0;
      ft      <= '0;
      phase   <= '0;
    end else if (pair_ok || timeout) begin
      hunting <= 1'b0;
      seen    <= 1'b0;
    end else if (hunting) begin
      if (tick) ft <= ft + 1'b1;
      if (pat) begin
        seen  <= 1'b1;
        far   <= 1'b0;
        phase <= '0;
      end else if (tick) begin
        far   <= 1'b1;
        phase <= (phase == MF_LAST) ? '0 : phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mf_resync_sup.sv
module mf_resync_sup
  import mfr_pkg::*;
#(
  parameter int unsigned MF_FRAMES  = DEF_MF_FRAMES,
  parameter int unsigned WIN_FRAMES = DEF_WIN_FRAMES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_tick,
  input  logic       df_sync,
  input  logic [1:0] fmt_sel,
  input  logic       auto_en,
  input  logic       frc_cmd,
  input  logic       mfrc_cmd,
  input  logic       mf_pat,
  output logic       df_search_req,
  output logic       mf_search_req,
  output logic       mf_aligned
);
  logic       crc_on;
  logic [2:0] rise;
  logic       arm;
  logic       pair_ok;
  logic       timeout;
  logic       df_nxt;
  logic       mf_nxt;

  assign crc_on = (fmt_sel == FMT_CRC);

  mfr_edge #(.N(3)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({df_sync, mfrc_cmd, frc_cmd}),
    .rise (rise)
  );

  assign arm = crc_on && (rise[0] || rise[1] || rise[2]);

  mfr_window #(.MF_FRAMES(MF_FRAMES), .WIN_FRAMES(WIN_FRAMES)) u_win (
    .clk     (clk),
    .rst     (rst),
    .crc_on  (crc_on),
    .auto_en (auto_en),
    .arm     (arm),
    .tick    (frame_tick),
    .pat     (mf_pat),
    .pair_ok (pair_ok),
    .timeout (timeout)
  );

  assign df_nxt = rise[0] || timeout;
  assign mf_nxt = crc_on && (rise[0] || rise[1] || timeout);

  always_ff @(posedge clk) begin
    if (rst) begin
      df_search_req <= 1'b0;
      mf_search_req <= 1'b0;
      mf_aligned    <= 1'b0;
    end else begin
      df_search_req <= df_nxt;
      mf_search_req <= mf_nxt;
      if (df_nxt || mf_nxt) mf_aligned <= 1'b0;
      else if (pair_ok)     mf_aligned <= 1'b1;
    end
  end
endmodule

// File: rtl/mfr_chk.sv
module mfr_chk
  import mfr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] fmt_sel,
  input logic       df_search_req,
  input logic       mf_search_req,
  input logic       mf_aligned
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!df_search_req && !mf_search_req && !mf_aligned));

  // R2
  df_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    df_search_req |=> !df_search_req);

  // R3
  mf_needs_crc_chk: assert property (@(posedge clk) disable iff (rst)
    mf_search_req |-> ($past(fmt_sel) == FMT_CRC));

  // R3
  full_in_crc_chk: assert property (@(posedge clk) disable iff (rst)
    (df_search_req && ($past(fmt_sel) == FMT_CRC)) |-> mf_search_req);

  // R9
  aligned_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (df_search_req || mf_search_req) |-> !mf_aligned);
endmodule

bind mf_resync_sup mfr_chk u_chk (.*);

// File: tb/sim_mf_resync_sup.sv
`timescale 1ns/1ps
module sim_mf_resync_sup;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0, df_sync = 1'b0, auto_en = 1'b0;
  logic frc_cmd = 1'b0, mfrc_cmd = 1'b0, mf_pat = 1'b0;
  logic [1:0] fmt_sel = 2'b00;
  logic df_search_req, mf_search_req, mf_aligned;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mf_resync_sup u0 (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .df_sync(df_sync),
    .fmt_sel(fmt_sel), .auto_en(auto_en), .frc_cmd(frc_cmd),
    .mfrc_cmd(mfrc_cmd), .mf_pat(mf_pat),
    .df_search_req(df_search_req), .mf_search_req(mf_search_req),
    .mf_aligned(mf_aligned)
  );

  // {fmt[1:0], frc, mfrc, exp_df, exp_mf}
  localparam logic [5:0] VEC [8] = '{
    6'b10_10_11, 6'b00_10_10, 6'b01_10_10, 6'b11_10_10,
    6'b10_01_01, 6'b00_01_00, 6'b01_01_00, 6'b11_01_00
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic pat();
    @(negedge clk); mf_pat = 1'b1;
    @(negedge clk); mf_pat = 1'b0;
  endtask

  task automatic mfrc_pulse();
    @(negedge clk); mfrc_cmd = 1'b1;
    @(negedge clk); mfrc_cmd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) cyc();
    chk("R1 df_req in reset", df_search_req, 1'b0);
    chk("R1 mf_req in reset", mf_search_req, 1'b0);
    chk("R1 aligned in reset", mf_aligned, 1'b0);
    rst = 1'b0;
    cyc();
    chk("R1 df_req after reset", df_search_req, 1'b0);
    chk("R1 aligned after reset", mf_aligned, 1'b0);

    // R2 R3 R4: command edges under every format code
    for (int i = 0; i < 8; i++) begin
      fmt_sel  = VEC[i][5:4];
      frc_cmd  = VEC[i][3];
      mfrc_cmd = VEC[i][2];
      cyc();
      chk(VEC[i][3] ? "R2 df_req on frc edge" : "R4 df_req on mfrc edge", df_search_req, VEC[i][1]);
      chk(VEC[i][3] ? "R3 mf_req on frc edge" : "R4 mf_req on mfrc edge", mf_search_req, VEC[i][0]);
      cyc();
      chk("R2 df_req held bit", df_search_req, 1'b0);
      chk("R2 mf_req held bit", mf_search_req, 1'b0);
      frc_cmd = 1'b0; mfrc_cmd = 1'b0;
      cyc();
    end

    // R5: arm on doubleframe regain, pair at 16 frames
    fmt_sel = 2'b10; auto_en = 1'b1;
    df_sync = 1'b1; cyc();
    pat();
    chk("R5 aligned after first pattern", mf_aligned, 1'b0);
    for (int k = 0; k < 16; k++) tick();
    pat();
    chk("R5 aligned after 16-frame pair", mf_aligned, 1'b1);

    // R9: multiframe command drops alignment with its request
    @(negedge clk); mfrc_cmd = 1'b1;
    @(negedge clk);
    chk("R9 mf_req on mfrc", mf_search_req, 1'b1);
    chk("R9 aligned low with request", mf_aligned, 1'b0);
    mfrc_cmd = 1'b0;

    // R6: 10-frame spacing rejected, next 16 from it accepted
    pat();
    for (int k = 0; k < 10; k++) tick();
    pat();
    chk("R6 aligned after 10-frame gap", mf_aligned, 1'b0);
    for (int k = 0; k < 16; k++) tick();
    pat();
    chk("R6 aligned after new reference", mf_aligned, 1'b1);

    // R7: window expiry escalates
    mfrc_pulse();
    for (int k = 0; k < 63; k++) tick();
    chk("R7 df_req at 63 frames", df_search_req, 1'b0);
    tick();
    chk("R7 df_req at 64 frames", df_search_req, 1'b1);
    chk("R7 mf_req at 64 frames", mf_search_req, 1'b1);
    cyc();
    chk("R7 df_req one clock", df_search_req, 1'b0);

    // R8: no escalation when disabled
    auto_en = 1'b0;
    mfrc_pulse();
    begin
      logic seen_req = 1'b0;
      for (int k = 0; k < 70; k++) begin
        tick();
        if (df_search_req || mf_search_req) seen_req = 1'b1;
      end
      chk("R8 request without auto", seen_req, 1'b0);
    end

    // R10: doubleframe regain restarts the window
    auto_en = 1'b1;
    mfrc_pulse();
    for (int k = 0; k < 40; k++) tick();
    @(negedge clk); df_sync = 1'b0;
    @(negedge clk); df_sync = 1'b1;
    cyc();
    for (int k = 0; k < 63; k++) tick();
    chk("R10 df_req 63 frames after restart", df_search_req, 1'b0);
    tick();
    chk("R10 df_req 64 frames after restart", df_search_req, 1'b1);
    cyc();

    summary();
  end
endmodule